// File: doc/BRIEF.md
# Cartridge Bank Switching Controller

This block sits on an 8-bit processor bus with a 16-bit address and turns write cycles aimed at the read-only half of the map (below 0x8000) into bank-select state. Software writes a byte to one of a few address ranges. The block then holds three pieces of state: a 9-bit number for the upper ROM window, a 4-bit number for the external RAM bank, and a flag that opens the RAM.

Using that state, the block translates every bus address into a physical address for the ROM array and for the RAM array. It also drives a select line for each array. The low 16 KiB ROM window always shows bank 0. The upper window shows the stored bank exactly as written, and bank 0 is a legal choice there. The bank state is held in registers. The address translation is combinational from the current bus address and those registers.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After a synchronous reset, the lower-window bank reads 0x000, the upper-window bank reads 0x001, the RAM bank reads 0x0, and RAM enable is 0.
- R2: A write with the address in 0x0000–0x1FFF sets RAM enable when the data byte equals 0x0A exactly. Any other byte, for example 0x1A, clears it.
- R3: A write with the address in 0x2000–0x2FFF copies the data byte into bits 7:0 of the upper-window bank. Bit 8 keeps its value.
- R4: A write with the address in 0x3000–0x3FFF copies data bit 0 into bit 8 of the upper-window bank. Data bits 7:1 are ignored and bits 7:0 of the bank keep their value.
- R5: Writing bank values 0x000 or 0x100 selects those banks unchanged, with no substitution of bank 1. The lower-window bank output stays 0x000 whatever is written.
- R6: A write with the address in 0x4000–0x5FFF copies data bits 3:0 into the RAM bank. Data bits 7:4 are ignored, so 0x1F gives 0xF and 0x7A gives 0xA.
- R7: The following change no state: writes to 0x6000–0x7FFF, writes to any address at or above 0x8000, and bus cycles with the write strobe low.
- R8: The ROM select is high for addresses below 0x8000. For addresses 0x0000–0x3FFF the ROM physical address (23 bits) is {9'h000, addr[13:0]}. For addresses 0x4000–0x7FFF it is {upper bank, addr[13:0]}.
- R9: The RAM physical address (17 bits) is {RAM bank, addr[12:0]}. The RAM select is high only when the address lies in 0xA000–0xBFFF and RAM enable is 1.
- R10: A reset asserted for a single clock cycle returns all state to the R1 values, regardless of earlier writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_wr | input | 1 | Write strobe; state is updated on the clock edge where this is high |
| lo_bank | output | 9 | Bank shown in the lower ROM window (always 0) |
| hi_bank | output | 9 | Bank shown in the upper ROM window |
| ram_bank | output | 4 | Selected external RAM bank |
| ram_on | output | 1 | RAM enable flag |
| rom_sel | output | 1 | ROM array select |
| rom_phys | output | 23 | Translated ROM address |
| ram_sel | output | 1 | RAM array select, gated by the enable flag |
| ram_phys | output | 17 | Translated RAM address |

## Verification
The bench goes after the RAM-enable key with near-miss bytes such as 0x1A and 0x0B. A design that compares only the low nibble would leave RAM open after those writes.

The two halves of the ROM bank are written in both orders, and bank 0 is selected for the upper window. A design that clobbers bit 8 on a low-byte write, or that swaps bank 0 for bank 1, shows a wrong upper-window bank and a wrong ROM address.

RAM-bank writes carry junk in the high nibble. Writes to 0x6000–0x7FFF and above 0x8000, and idle bus cycles, are all checked for leaving every output unchanged, which catches an incomplete address decode. RAM select is probed both with the enable flag off and with the address just outside 0xA000–0xBFFF.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

  typedef enum logic [2:0] {
    WSEL_NONE,
    WSEL_RAM_EN,
    WSEL_ROM_LO,
    WSEL_ROM_HI,
    WSEL_RAM_BANK
  } wsel_e;

  localparam logic [7:0] RAM_UNLOCK_KEY = 8'h0A;

  // Decode from address bits [15:12] of a write cycle.
  function automatic wsel_e decode_wr(input logic [3:0] top_nib);
    wsel_e s;
    case (top_nib)
      4'h0, 4'h1: s = WSEL_RAM_EN;
      4'h2:       s = WSEL_ROM_LO;
      4'h3:       s = WSEL_ROM_HI;
      4'h4, 4'h5: s = WSEL_RAM_BANK;
      default:    s = WSEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/cart_wr_decode.sv
module cart_wr_decode
  import cart_bank_pkg::*;
(
  input  logic [3:0] addr_nib,
  input  logic       wr,
  output wsel_e      sel
);
  always_comb begin
    sel = WSEL_NONE;
    if (wr) sel = decode_wr(addr_nib);
  end
endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
  import cart_bank_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int RAM_BANK_W = 4,
  localparam int ROM_BANK_W = DATA_W + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  wsel_e                 sel,
  input  logic [DATA_W-1:0]     wdata,
  output logic [ROM_BANK_W-1:0] hi_bank_q,
  output logic [RAM_BANK_W-1:0] ram_bank_q,
  output logic                  ram_on_q
);
  localparam logic [ROM_BANK_W-1:0] HI_RESET = ROM_BANK_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_bank_q  <= HI_RESET;
      ram_bank_q <= '0;
      ram_on_q   <= 1'b0;
    end else begin
      case (sel)
        WSEL_RAM_EN:   ram_on_q <= (wdata == DATA_W'(RAM_UNLOCK_KEY));
        WSEL_ROM_LO:   hi_bank_q[DATA_W-1:0] <= wdata;
        WSEL_ROM_HI:   hi_bank_q[ROM_BANK_W-1] <= wdata[0];
        WSEL_RAM_BANK: ram_bank_q <= wdata[RAM_BANK_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cart_rom_map.sv
module cart_rom_map #(
  parameter int BANK_W = 9,
  parameter int WIN_W  = 14,
  localparam int PHYS_W = BANK_W + WIN_W
) (
  input  logic [1:0]        addr_top,
  input  logic [WIN_W-1:0]  addr_off,
  input  logic [BANK_W-1:0] hi_bank,
  output logic              sel,
  output logic [PHYS_W-1:0] phys
);
  always_comb begin
    sel  = ~addr_top[1];
    phys = {(addr_top[0] ? hi_bank : BANK_W'(0)), addr_off};
  end
endmodule

// File: rtl/cart_ram_map.sv
module cart_ram_map #(
  parameter int BANK_W = 4,
  parameter int WIN_W  = 13,
  localparam int PHYS_W = BANK_W + WIN_W
) (
  input  logic [2:0]        addr_top,
  input  logic [WIN_W-1:0]  addr_off,
  input  logic [BANK_W-1:0] bank,
  input  logic              enable,
  output logic              sel,
  output logic [PHYS_W-1:0] phys
);
  localparam logic [2:0] RAM_SLOT = 3'b101;

  always_comb begin
    sel  = enable && (addr_top == RAM_SLOT);
    phys = {bank, addr_off};
  end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_bank_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int RAM_BANK_W = 4,
  localparam int ROM_BANK_W = DATA_W + 1,
  localparam int ROM_WIN_W  = ADDR_W - 2,
  localparam int RAM_WIN_W  = ADDR_W - 3,
  localparam int ROM_PHYS_W = ROM_BANK_W + ROM_WIN_W,
  localparam int RAM_PHYS_W = RAM_BANK_W + RAM_WIN_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic                  bus_wr,
  output logic [ROM_BANK_W-1:0] lo_bank,
  output logic [ROM_BANK_W-1:0] hi_bank,
  output logic [RAM_BANK_W-1:0] ram_bank,
  output logic                  ram_on,
  output logic                  rom_sel,
  output logic [ROM_PHYS_W-1:0] rom_phys,
  output logic                  ram_sel,
  output logic [RAM_PHYS_W-1:0] ram_phys
);
  wsel_e wsel;

  cart_wr_decode u_dec (
    .addr_nib (bus_addr[ADDR_W-1:ADDR_W-4]),
    .wr       (bus_wr),
    .sel      (wsel)
  );

  cart_bank_regs #(.DATA_W(DATA_W), .RAM_BANK_W(RAM_BANK_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .sel        (wsel),
    .wdata      (bus_wdata),
    .hi_bank_q  (hi_bank),
    .ram_bank_q (ram_bank),
    .ram_on_q   (ram_on)
  );

  assign lo_bank = '0;

  cart_rom_map #(.BANK_W(ROM_BANK_W), .WIN_W(ROM_WIN_W)) u_rom (
    .addr_top (bus_addr[ADDR_W-1:ADDR_W-2]),
    .addr_off (bus_addr[ROM_WIN_W-1:0]),
    .hi_bank  (hi_bank),
    .sel      (rom_sel),
    .phys     (rom_phys)
  );

  cart_ram_map #(.BANK_W(RAM_BANK_W), .WIN_W(RAM_WIN_W)) u_ram (
    .addr_top (bus_addr[ADDR_W-1:ADDR_W-3]),
    .addr_off (bus_addr[RAM_WIN_W-1:0]),
    .bank     (ram_bank),
    .enable   (ram_on),
    .sel      (ram_sel),
    .phys     (ram_phys)
  );
endmodule

// File: rtl/cart_bank_ctrl_chk.sv
module cart_bank_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] bus_addr,
  input logic [7:0]  bus_wdata,
  input logic        bus_wr,
  input logic [8:0]  hi_bank,
  input logic [3:0]  ram_bank,
  input logic        ram_on,
  input logic        ram_sel,
  input logic [22:0] rom_phys
);
  logic wr_en_rng, wr_lo_rng, wr_bank_rng, wr_any;
  assign wr_en_rng   = bus_wr && (bus_addr[15:13] == 3'b000);
  assign wr_lo_rng   = bus_wr && (bus_addr[15:12] == 4'h2);
  assign wr_bank_rng = bus_wr && (bus_addr[15:13] == 3'b010);
  assign wr_any      = bus_wr && (bus_addr < 16'h6000);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $fell(rst) |-> (hi_bank == 9'h001 && ram_bank == 4'h0 && !ram_on));

  // R2
  ram_key_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_rng |=> (ram_on == ($past(bus_wdata) == 8'h0A)));

  // R3
  rom_low_chk: assert property (@(posedge clk) disable iff (rst)
    wr_lo_rng |=> (hi_bank[7:0] == $past(bus_wdata) && hi_bank[8] == $past(hi_bank[8])));

  // R6
  ram_bank_chk: assert property (@(posedge clk) disable iff (rst)
    wr_bank_rng |=> (ram_bank == $past(bus_wdata[3:0])));

  // R7
  no_write_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_any |=> ($stable(hi_bank) && $stable(ram_bank) && $stable(ram_on)));

  // R9
  ram_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ram_sel |-> (ram_on && bus_addr[15:13] == 3'b101));

  // R8
  rom_low_win_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr[15:14] == 2'b00) |-> (rom_phys[22:14] == 9'h000));
endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .hi_bank(hi_bank), .ram_bank(ram_bank), .ram_on(ram_on),
  .ram_sel(ram_sel), .rom_phys(rom_phys)
);

// File: tb/cart_bank_ctrl_tb.sv
module cart_bank_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic [8:0]  lo_bank, hi_bank;
  logic [3:0]  ram_bank;
  logic        ram_on, rom_sel, ram_sel;
  logic [22:0] rom_phys;
  logic [16:0] ram_phys;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cart_bank_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .lo_bank(lo_bank), .hi_bank(hi_bank),
    .ram_bank(ram_bank), .ram_on(ram_on), .rom_sel(rom_sel),
    .rom_phys(rom_phys), .ram_sel(ram_sel), .ram_phys(ram_phys)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic probe(input logic [15:0] a);
    @(negedge clk);
    bus_addr = a;
    #1;
  endtask

  task automatic t_reset();
    chk("R1 lo", 32'(lo_bank), 32'h000);
    chk("R1 hi", 32'(hi_bank), 32'h001);
    chk("R1 rambank", 32'(ram_bank), 32'h0);
    chk("R1 ram_on", 32'(ram_on), 32'h0);
  endtask

  task automatic t_ram_en();
    wr(16'h0000, 8'h0A); chk("R2 key", 32'(ram_on), 1);
    wr(16'h1FFF, 8'h1A); chk("R2 0x1A", 32'(ram_on), 0);
    wr(16'h1234, 8'h0A); chk("R2 key mid", 32'(ram_on), 1);
    wr(16'h0000, 8'h0B); chk("R2 0x0B", 32'(ram_on), 0);
  endtask

  task automatic t_rom_bank();
    wr(16'h2000, 8'h42); chk("R3 low", 32'(hi_bank), 32'h042);
    wr(16'h3000, 8'h01); chk("R4 set8", 32'(hi_bank), 32'h142);
    wr(16'h2FFF, 8'h7E); chk("R3 keep8", 32'(hi_bank), 32'h17E);
    wr(16'h3FFF, 8'hFE); chk("R4 data0only", 32'(hi_bank), 32'h07E);
  endtask

  task automatic t_bank_zero();
    wr(16'h2000, 8'h00); chk("R5 bank0", 32'(hi_bank), 32'h000);
    wr(16'h3000, 8'h01); chk("R5 bank100", 32'(hi_bank), 32'h100);
    chk("R5 lo fixed", 32'(lo_bank), 32'h000);
    wr(16'h3000, 8'h00); chk("R5 bank0 again", 32'(hi_bank), 32'h000);
  endtask

  task automatic t_ram_bank();
    wr(16'h4000, 8'h1F); chk("R6 1F", 32'(ram_bank), 32'hF);
    wr(16'h5FFF, 8'h7A); chk("R6 7A", 32'(ram_bank), 32'hA);
  endtask

  task automatic t_ignored();
    wr(16'h2000, 8'h33); wr(16'h0000, 8'h0A); wr(16'h4000, 8'h05);
    wr(16'h6000, 8'h00); wr(16'h7FFF, 8'hFF);
    wr(16'h8000, 8'h0B); wr(16'hA000, 8'h07); wr(16'hFFFF, 8'h00);
    idle(16'h2000, 8'h99); idle(16'h0000, 8'h00); idle(16'h4000, 8'h0C);
    chk("R7 hi", 32'(hi_bank), 32'h033);
    chk("R7 ram_on", 32'(ram_on), 1);
    chk("R7 rambank", 32'(ram_bank), 32'h5);
  endtask

  task automatic t_rom_map();
    wr(16'h2000, 8'h42); wr(16'h3000, 8'h01);
    probe(16'h0123); chk("R8 low win", 32'(rom_phys), 32'h0000123);
    chk("R8 rom_sel", 32'(rom_sel), 1);
    probe(16'h7FFF); chk("R8 hi win", 32'(rom_phys), {9'h0, 9'h142, 14'h3FFF});
    probe(16'h4001); chk("R8 hi win2", 32'(rom_phys), {9'h0, 9'h142, 14'h0001});
    probe(16'h8000); chk("R8 rom_sel off", 32'(rom_sel), 0);
  endtask

  task automatic t_ram_map();
    wr(16'h4000, 8'h03); wr(16'h0000, 8'h00);
    probe(16'hA123); chk("R9 sel off", 32'(ram_sel), 0);
    wr(16'h0000, 8'h0A);
    probe(16'hA123); chk("R9 sel on", 32'(ram_sel), 1);
    chk("R9 phys", 32'(ram_phys), {15'h0, 4'h3, 13'h0123});
    probe(16'hC000); chk("R9 above", 32'(ram_sel), 0);
    probe(16'h9FFF); chk("R9 below", 32'(ram_sel), 0);
  endtask

  task automatic t_sync_reset();
    wr(16'h2000, 8'h55); wr(16'h3000, 8'h01);
    wr(16'h4000, 8'h09); wr(16'h0000, 8'h0A);
    pulse_reset();
    chk("R10 hi", 32'(hi_bank), 32'h001);
    chk("R10 rambank", 32'(ram_bank), 32'h0);
    chk("R10 ram_on", 32'(ram_on), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ram_en();
    t_rom_bank();
    t_bank_zero();
    t_ram_bank();
    t_ignored();
    t_rom_map();
    t_ram_map();
    t_sync_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule